// File: doc/BRIEF.md
# Storage DMA Channel Control and Status Registers

This block is the software-visible control layer for a packet-driven storage DMA engine with several channels. A simple register port (request valid/ready, read response one cycle later) reaches one global key register and one register window per channel. Each window holds a control word, a status word, a packet count, a next-packet pointer and two FIFO thresholds. The block drives the engine's reset, start and interrupt-mask lines and the configuration values. It takes back error and stop event pulses, which it turns into sticky status flags and an interrupt.

Packet start is protected. A start request in the control word only launches the engine when the global key register holds the enabling value. Setting the engine-reset bit holds the engine idle, blocks any start and returns the channel from packet mode to plain register-access mode. Status flags clear when they are read, and an event that lands in the cycle of the read is not lost.

Top module: `sdma_chan_csr`

## Requirements
- R1: After reset every control word reads 0x0100 (interrupt masked, timing mode 0, engine reset off), status, counts, pointers, thresholds and the key register read 0, and eng_start, eng_reset, pkt_active and irq are all low.
- R2: Channel c occupies addresses 0x80 + 0x20*c. Within a window, control is at offset 0x00 (bit 8 interrupt mask, bit 7 start, bit 5 engine reset, bits 1:0 timing mode), status at 0x02, packet count at 0x04 (16 bits), next-packet pointer at 0x0C (32 bits), input threshold at 0x14 and output threshold at 0x16 (16 bits each). Values written read back and appear on the matching outputs. A read's data appears on rsp_rdata with rsp_valid one cycle after the request is accepted.
- R3: When the key register at 0xC7 holds 0x07, a control write with bit 7 set and bit 5 clear makes eng_start of that channel high for exactly one cycle, in the cycle after the write. Bit 7 always reads back as 0, and pkt_active goes high with the pulse.
- R4: When the key register holds any value other than 0x07, a control write with bit 7 set produces no start pulse and leaves pkt_active low.
- R5: While control bit 5 is 1, eng_reset is high, no start pulse is produced (even if bit 7 is written in the same word), and pkt_active is cleared. pkt_active stays low after bit 5 is cleared until the next start.
- R6: Event pulses set sticky status bits: evt_perr sets bit 0, evt_uirq sets bit 4, evt_stop sets bit 6. They stay set until the status word is read.
- R7: A status read returns the bits latched before the read and clears them. An event that arrives in the same cycle as the read is set afterwards and shows on the next read.
- R8: irq of a channel is high exactly when any of its status bits is set and its control bit 8 is 0.
- R9: Reads of unmapped offsets or addresses return 0. Writes to them change no register. Accesses to one channel do not change the other channel.
- R10: req_ready is always high, so every request is accepted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| evt_perr | input | NUM_CH | Parity/bus error event pulse per channel |
| evt_uirq | input | NUM_CH | Unexpected device interrupt event per channel |
| evt_stop | input | NUM_CH | Packet-stopped event per channel |
| eng_reset | output | NUM_CH | Engine reset hold per channel |
| eng_start | output | NUM_CH | One-cycle packet start per channel |
| irq_mask | output | NUM_CH | Interrupt mask state per channel |
| pkt_active | output | NUM_CH | Channel in packet mode |
| timing_mode | output | NUM_CH*2 | Transfer timing mode per channel |
| pkt_count | output | NUM_CH*CNT_W | Packet count per channel |
| next_ptr | output | NUM_CH*PTR_W | Next-packet pointer per channel |
| fifo_in_thr | output | NUM_CH*THR_W | Input FIFO threshold per channel |
| fifo_out_thr | output | NUM_CH*THR_W | Output FIFO threshold per channel |
| irq | output | NUM_CH | Interrupt request per channel |

## Verification
The bound checker watches on every cycle that a start pulse is one cycle wide, only occurs with the key loaded and never while engine reset is held, that engine reset and packet mode never coexist, that each event pulse is latched the next cycle, that a masked channel never interrupts, and that each read gets a response one cycle later. Only the bench scenarios show the register map itself: readback values at each offset, window placement per channel, clear-on-read with a racing event, the effect of unmapped writes, and the exact encodings in the control and status words.

// File: rtl/sdma_csr_pkg.sv
package sdma_csr_pkg;

    localparam int OFF_W = 5;

    localparam logic [OFF_W-1:0] OFF_CTRL = 5'h00;
    localparam logic [OFF_W-1:0] OFF_STAT = 5'h02;
    localparam logic [OFF_W-1:0] OFF_CNT  = 5'h04;
    localparam logic [OFF_W-1:0] OFF_PTR  = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_FIN  = 5'h14;
    localparam logic [OFF_W-1:0] OFF_FOUT = 5'h16;

    localparam int CTL_MASK_BIT = 8;
    localparam int CTL_GO_BIT   = 7;
    localparam int CTL_RST_BIT  = 5;

    localparam int STS_PERR_BIT = 0;
    localparam int STS_UIRQ_BIT = 4;
    localparam int STS_STOP_BIT = 6;

    // compact order of the latched flags inside a channel
    localparam int FLAG_PERR = 0;
    localparam int FLAG_UIRQ = 1;
    localparam int FLAG_STOP = 2;
    localparam int NUM_FLAGS = 3;

    typedef enum logic [1:0] {
        TM_SLOW0 = 2'd0,
        TM_SLOW1 = 2'd1,
        TM_MID   = 2'd2,
        TM_FAST  = 2'd3
    } timing_mode_e;

endpackage

// File: rtl/sdma_addr_dec.sv
module sdma_addr_dec
    import sdma_csr_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 8,
    parameter int CH_BASE   = 'h80,
    parameter int CH_STRIDE = 'h20,
    parameter int LOCK_ADDR = 'hC7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_lock,
    output logic [NUM_CH-1:0] ch_sel,
    output logic [OFF_W-1:0]  offs
);

    always_comb begin
        hit_lock = (int'(addr) == LOCK_ADDR);
        ch_sel   = '0;
        offs     = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            int rel;
            rel = int'(addr) - CH_BASE - ch * CH_STRIDE;
            if (rel >= 0 && rel < CH_STRIDE) begin
                ch_sel[ch] = 1'b1;
                offs       = rel[OFF_W-1:0];
            end
        end
    end

endmodule

// File: rtl/sdma_chan_regs.sv
module sdma_chan_regs
    import sdma_csr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PTR_W  = 32,
    parameter int THR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFF_W-1:0]  offs,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock_ok,
    input  logic              evt_perr,
    input  logic              evt_uirq,
    input  logic              evt_stop,
    output logic [DATA_W-1:0] rdata,
    output logic              eng_reset,
    output logic              eng_start,
    output logic              irq_mask,
    output logic              pkt_active,
    output logic [1:0]        timing_mode,
    output logic [CNT_W-1:0]  pkt_count,
    output logic [PTR_W-1:0]  next_ptr,
    output logic [THR_W-1:0]  fifo_in_thr,
    output logic [THR_W-1:0]  fifo_out_thr,
    output logic [NUM_FLAGS-1:0] flags,
    output logic              irq
);

    typedef struct packed {
        logic                 mask;
        logic                 rst;
        timing_mode_e         mode;
        logic [CNT_W-1:0]     cnt;
        logic [PTR_W-1:0]     ptr;
        logic [THR_W-1:0]     fin;
        logic [THR_W-1:0]     fout;
        logic [NUM_FLAGS-1:0] stat;
        logic                 start;
        logic                 active;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [NUM_FLAGS-1:0] evt_vec;
    logic [NUM_FLAGS-1:0] stat_keep;
    logic                 stat_rd;

    always_comb begin
        evt_vec            = '0;
        evt_vec[FLAG_PERR] = evt_perr;
        evt_vec[FLAG_UIRQ] = evt_uirq;
        evt_vec[FLAG_STOP] = evt_stop;
        stat_rd            = rd_en && (offs == OFF_STAT);
        stat_keep          = stat_rd ? '0 : st_q.stat;

        st_d       = st_q;
        st_d.start = 1'b0;
        if (wr_en) begin
            case (offs)
                OFF_CTRL: begin
                    st_d.mask = wdata[CTL_MASK_BIT];
                    st_d.rst  = wdata[CTL_RST_BIT];
                    st_d.mode = timing_mode_e'(wdata[1:0]);
                    if (wdata[CTL_GO_BIT] && lock_ok && !wdata[CTL_RST_BIT]) begin
                        st_d.start = 1'b1;
                    end
                end
                OFF_CNT:  st_d.cnt  = wdata[CNT_W-1:0];
                OFF_PTR:  st_d.ptr  = wdata[PTR_W-1:0];
                OFF_FIN:  st_d.fin  = wdata[THR_W-1:0];
                OFF_FOUT: st_d.fout = wdata[THR_W-1:0];
                default:  ;
            endcase
        end
        if (st_d.rst) begin
            st_d.active = 1'b0;
        end else if (st_d.start) begin
            st_d.active = 1'b1;
        end
        st_d.stat = stat_keep | evt_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (offs)
            OFF_CTRL: begin
                rdata[CTL_MASK_BIT] = st_q.mask;
                rdata[CTL_RST_BIT]  = st_q.rst;
                rdata[1:0]          = st_q.mode;
            end
            OFF_STAT: begin
                rdata[STS_PERR_BIT] = st_q.stat[FLAG_PERR];
                rdata[STS_UIRQ_BIT] = st_q.stat[FLAG_UIRQ];
                rdata[STS_STOP_BIT] = st_q.stat[FLAG_STOP];
            end
            OFF_CNT:  rdata = DATA_W'(st_q.cnt);
            OFF_PTR:  rdata = DATA_W'(st_q.ptr);
            OFF_FIN:  rdata = DATA_W'(st_q.fin);
            OFF_FOUT: rdata = DATA_W'(st_q.fout);
            default:  rdata = '0;
        endcase
    end

    assign eng_reset    = st_q.rst;
    assign eng_start    = st_q.start;
    assign irq_mask     = st_q.mask;
    assign pkt_active   = st_q.active;
    assign timing_mode  = st_q.mode;
    assign pkt_count    = st_q.cnt;
    assign next_ptr     = st_q.ptr;
    assign fifo_in_thr  = st_q.fin;
    assign fifo_out_thr = st_q.fout;
    assign flags        = st_q.stat;
    assign irq          = (|st_q.stat) && !st_q.mask;

endmodule

// File: rtl/sdma_chan_csr.sv
module sdma_chan_csr
    import sdma_csr_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter int PTR_W     = 32,
    parameter int THR_W     = 16,
    parameter int CH_BASE   = 'h80,
    parameter int CH_STRIDE = 'h20,
    parameter int LOCK_ADDR = 'hC7,
    parameter int LOCK_W    = 8,
    parameter int LOCK_KEY  = 'h07
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    input  logic [NUM_CH-1:0]        evt_perr,
    input  logic [NUM_CH-1:0]        evt_uirq,
    input  logic [NUM_CH-1:0]        evt_stop,
    output logic [NUM_CH-1:0]        eng_reset,
    output logic [NUM_CH-1:0]        eng_start,
    output logic [NUM_CH-1:0]        irq_mask,
    output logic [NUM_CH-1:0]        pkt_active,
    output logic [NUM_CH*2-1:0]      timing_mode,
    output logic [NUM_CH*CNT_W-1:0]  pkt_count,
    output logic [NUM_CH*PTR_W-1:0]  next_ptr,
    output logic [NUM_CH*THR_W-1:0]  fifo_in_thr,
    output logic [NUM_CH*THR_W-1:0]  fifo_out_thr,
    output logic [NUM_CH-1:0]        irq
);

    localparam int FLAGS_W = NUM_CH * NUM_FLAGS;

    typedef struct packed {
        logic [LOCK_W-1:0] lock;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                    hit_lock;
    logic [NUM_CH-1:0]       ch_sel;
    logic [OFF_W-1:0]        offs;
    logic                    acc_rd;
    logic                    acc_wr;
    logic                    lock_ok;
    logic [LOCK_W-1:0]       lock_val;
    logic [DATA_W-1:0]       ch_rdata [NUM_CH];
    logic [FLAGS_W-1:0]      stat_flat;
    logic [DATA_W-1:0]       rd_mux;

    assign req_ready = 1'b1;
    assign acc_rd    = req_valid && !req_write;
    assign acc_wr    = req_valid && req_write;
    assign lock_val  = st_q.lock;
    assign lock_ok   = (st_q.lock == LOCK_W'(LOCK_KEY));

    sdma_addr_dec #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .CH_BASE   (CH_BASE),
        .CH_STRIDE (CH_STRIDE),
        .LOCK_ADDR (LOCK_ADDR)
    ) dec_i (
        .addr     (req_addr),
        .hit_lock (hit_lock),
        .ch_sel   (ch_sel),
        .offs     (offs)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sdma_chan_regs #(
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W),
            .PTR_W  (PTR_W),
            .THR_W  (THR_W)
        ) chan_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (acc_wr && ch_sel[c]),
            .rd_en        (acc_rd && ch_sel[c]),
            .offs         (offs),
            .wdata        (req_wdata),
            .lock_ok      (lock_ok),
            .evt_perr     (evt_perr[c]),
            .evt_uirq     (evt_uirq[c]),
            .evt_stop     (evt_stop[c]),
            .rdata        (ch_rdata[c]),
            .eng_reset    (eng_reset[c]),
            .eng_start    (eng_start[c]),
            .irq_mask     (irq_mask[c]),
            .pkt_active   (pkt_active[c]),
            .timing_mode  (timing_mode[c*2 +: 2]),
            .pkt_count    (pkt_count[c*CNT_W +: CNT_W]),
            .next_ptr     (next_ptr[c*PTR_W +: PTR_W]),
            .fifo_in_thr  (fifo_in_thr[c*THR_W +: THR_W]),
            .fifo_out_thr (fifo_out_thr[c*THR_W +: THR_W]),
            .flags        (stat_flat[c*NUM_FLAGS +: NUM_FLAGS]),
            .irq          (irq[c])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (hit_lock) begin
            rd_mux = DATA_W'(st_q.lock);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel[c]) begin
                rd_mux = ch_rdata[c];
            end
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = acc_rd;
        if (acc_rd) begin
            st_d.rdata = rd_mux;
        end
        if (acc_wr && hit_lock) begin
            st_d.lock = req_wdata[LOCK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rvalid;
    assign rsp_rdata = st_q.rdata;

endmodule

// File: rtl/sdma_chan_csr_chk.sv
module sdma_chan_csr_chk
    import sdma_csr_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int LOCK_W   = 8,
    parameter int LOCK_KEY = 'h07
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_write,
    input logic                          rsp_valid,
    input logic [NUM_CH-1:0]             evt_perr,
    input logic [NUM_CH-1:0]             evt_uirq,
    input logic [NUM_CH-1:0]             evt_stop,
    input logic [NUM_CH-1:0]             eng_reset,
    input logic [NUM_CH-1:0]             eng_start,
    input logic [NUM_CH-1:0]             irq_mask,
    input logic [NUM_CH-1:0]             pkt_active,
    input logic [NUM_CH-1:0]             irq,
    input logic [LOCK_W-1:0]             lock_val,
    input logic [NUM_CH*NUM_FLAGS-1:0]   stat_flat
);

    // R2: every accepted read is answered in the next cycle
    p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[c] |=> !eng_start[c]);

        p_start_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[c] |-> pkt_active[c]);

        p_start_keyed_r4: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[c] |-> (lock_val == LOCK_W'(LOCK_KEY)));

        p_start_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[c] |-> !eng_reset[c]);

        p_reset_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            eng_reset[c] |-> !pkt_active[c]);

        p_perr_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
            evt_perr[c] |=> stat_flat[c*NUM_FLAGS + FLAG_PERR]);

        p_uirq_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
            evt_uirq[c] |=> stat_flat[c*NUM_FLAGS + FLAG_UIRQ]);

        p_stop_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
            evt_stop[c] |=> stat_flat[c*NUM_FLAGS + FLAG_STOP]);

        p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_mask[c] |-> !irq[c]);

        p_flags_need_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> (stat_flat[c*NUM_FLAGS +: NUM_FLAGS] != '0));
    end

endmodule

bind sdma_chan_csr sdma_chan_csr_chk #(
    .NUM_CH   (NUM_CH),
    .LOCK_W   (LOCK_W),
    .LOCK_KEY (LOCK_KEY)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .evt_perr   (evt_perr),
    .evt_uirq   (evt_uirq),
    .evt_stop   (evt_stop),
    .eng_reset  (eng_reset),
    .eng_start  (eng_start),
    .irq_mask   (irq_mask),
    .pkt_active (pkt_active),
    .irq        (irq),
    .lock_val   (lock_val),
    .stat_flat  (stat_flat)
);

// File: tb/sdma_chan_csr_tb.sv
module sdma_chan_csr_tb_top;

    localparam int NUM_CH = 2;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic                    req_write = 1'b0;
    logic [ADDR_W-1:0]       req_addr = '0;
    logic [DATA_W-1:0]       req_wdata = '0;
    logic                    rsp_valid;
    logic [DATA_W-1:0]       rsp_rdata;
    logic [NUM_CH-1:0]       evt_perr = '0;
    logic [NUM_CH-1:0]       evt_uirq = '0;
    logic [NUM_CH-1:0]       evt_stop = '0;
    logic [NUM_CH-1:0]       eng_reset, eng_start, irq_mask, pkt_active, irq;
    logic [NUM_CH*2-1:0]     timing_mode;
    logic [NUM_CH*16-1:0]    pkt_count;
    logic [NUM_CH*32-1:0]    next_ptr;
    logic [NUM_CH*16-1:0]    fifo_in_thr, fifo_out_thr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdma_chan_csr dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .evt_perr     (evt_perr),
        .evt_uirq     (evt_uirq),
        .evt_stop     (evt_stop),
        .eng_reset    (eng_reset),
        .eng_start    (eng_start),
        .irq_mask     (irq_mask),
        .pkt_active   (pkt_active),
        .timing_mode  (timing_mode),
        .pkt_count    (pkt_count),
        .next_ptr     (next_ptr),
        .fifo_in_thr  (fifo_in_thr),
        .fifo_out_thr (fifo_out_thr),
        .irq          (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = rsp_rdata;
        chk("R2 rsp_valid", 32'(rsp_valid), 32'd1);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R10 req_ready", 32'(req_ready), 32'd1);
        chk("R1 eng_start", 32'(eng_start), 32'd0);
        chk("R1 eng_reset", 32'(eng_reset), 32'd0);
        chk("R1 pkt_active", 32'(pkt_active), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        rd(8'h80, d); chk("R1 ctrl ch0", d, 32'h0100);
        rd(8'hA0, d); chk("R1 ctrl ch1", d, 32'h0100);
        rd(8'h82, d); chk("R1 status ch0", d, 32'h0);
        rd(8'h8C, d); chk("R1 ptr ch0", d, 32'h0);
        rd(8'hC7, d); chk("R1 key", d, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(8'h84, 32'h0001);
        wr(8'h8C, 32'h1234_5678);
        wr(8'h94, 32'h0100);
        wr(8'h96, 32'h0100);
        wr(8'h80, 32'h0103);
        rd(8'h84, d); chk("R2 count", d, 32'h0001);
        rd(8'h8C, d); chk("R2 pointer", d, 32'h1234_5678);
        rd(8'h94, d); chk("R2 in thr", d, 32'h0100);
        rd(8'h96, d); chk("R2 out thr", d, 32'h0100);
        rd(8'h80, d); chk("R2 ctrl", d, 32'h0103);
        chk("R2 timing out", 32'(timing_mode[1:0]), 32'd3);
        chk("R2 count out", 32'(pkt_count[15:0]), 32'h1);
        chk("R2 ptr out", next_ptr[31:0], 32'h1234_5678);
        chk("R2 thr out", 32'(fifo_in_thr[15:0]), 32'h100);
        chk("R2 thr out2", 32'(fifo_out_thr[15:0]), 32'h100);
    endtask

    task automatic t_windows();
        logic [31:0] d;
        wr(8'hA4, 32'h0055);
        chk("R2 ch1 count out", 32'(pkt_count[31:16]), 32'h55);
        rd(8'hA4, d); chk("R2 ch1 count", d, 32'h55);
        rd(8'h84, d); chk("R9 ch0 untouched", d, 32'h1);
        rd(8'hAC, d); chk("R9 ch1 ptr untouched", d, 32'h0);
        wr(8'h88, 32'hFFFF_FFFF);
        wr(8'hC0, 32'hFFFF_FFFF);
        rd(8'h88, d); chk("R9 unmapped offset", d, 32'h0);
        rd(8'hC0, d); chk("R9 unmapped addr", d, 32'h0);
        rd(8'h8C, d); chk("R9 ptr after unmapped wr", d, 32'h1234_5678);
        rd(8'h80, d); chk("R9 ctrl after unmapped wr", d, 32'h0103);
        rd(8'hC7, d); chk("R9 key after unmapped wr", d, 32'h0);
    endtask

    task automatic t_start_unlocked();
        wr(8'h80, 32'h0183);
        chk("R4 no start key 0", 32'(eng_start), 32'd0);
        chk("R4 no active", 32'(pkt_active), 32'd0);
        wr(8'hC7, 32'h05);
        wr(8'h80, 32'h0183);
        chk("R4 no start key 5", 32'(eng_start), 32'd0);
    endtask

    task automatic t_start_locked();
        logic [31:0] d;
        wr(8'hC7, 32'h07);
        rd(8'hC7, d); chk("R3 key readback", d, 32'h07);
        wr(8'h80, 32'h0183);
        chk("R3 start pulse", 32'(eng_start), 32'b01);
        chk("R3 active", 32'(pkt_active), 32'b01);
        @(negedge clk);
        chk("R3 pulse one cycle", 32'(eng_start), 32'd0);
        rd(8'h80, d); chk("R3 go reads 0", d, 32'h0103);
    endtask

    task automatic t_reset_bit();
        logic [31:0] d;
        wr(8'h80, 32'h01A3);
        chk("R5 eng_reset", 32'(eng_reset), 32'b01);
        chk("R5 start blocked", 32'(eng_start), 32'd0);
        chk("R5 active cleared", 32'(pkt_active), 32'd0);
        rd(8'h80, d); chk("R5 ctrl", d, 32'h0123);
        wr(8'h80, 32'h0103);
        chk("R5 reset released", 32'(eng_reset), 32'd0);
        chk("R5 stays idle", 32'(pkt_active), 32'd0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        wr(8'h80, 32'h0003);
        chk("R8 unmasked no flags", 32'(irq), 32'd0);
        @(negedge clk); evt_perr[0] = 1'b1;
        @(negedge clk); evt_perr[0] = 1'b0;
        chk("R8 irq raised", 32'(irq), 32'b01);
        @(negedge clk); evt_stop[0] = 1'b1;
        @(negedge clk); evt_stop[0] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 sticky irq", 32'(irq), 32'b01);
        rd(8'h82, d); chk("R6 status bits", d, 32'h41);
        chk("R7 irq after clear", 32'(irq), 32'd0);
        rd(8'h82, d); chk("R7 cleared", d, 32'h0);
    endtask

    task automatic t_clear_race();
        logic [31:0] d;
        @(negedge clk); evt_uirq[0] = 1'b1;
        @(negedge clk); evt_uirq[0] = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h82; evt_stop[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        d = rsp_rdata;
        req_valid = 1'b0; evt_stop[0] = 1'b0;
        chk("R7 read before race", d, 32'h10);
        chk("R7 race irq", 32'(irq), 32'b01);
        rd(8'h82, d); chk("R7 racing event kept", d, 32'h40);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        @(negedge clk); evt_perr[1] = 1'b1;
        @(negedge clk); evt_perr[1] = 1'b0;
        chk("R8 masked ch1", 32'(irq), 32'd0);
        wr(8'hA0, 32'h0000);
        chk("R8 unmask shows flag", 32'(irq), 32'b10);
        rd(8'hA2, d); chk("R6 ch1 perr", d, 32'h01);
        chk("R8 ch1 cleared", 32'(irq), 32'd0);
        rd(8'h82, d); chk("R9 ch0 status untouched", d, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_windows();
        t_start_unlocked();
        t_start_locked();
        t_reset_bit();
        t_status();
        t_clear_race();
        t_mask();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule